// File: doc/BRIEF.md
# Pixel Sync Pulse Generator

This block produces the per-pixel sample sync pulse used by downstream sampling timing. It has two modes. In pass-through mode the level on the external sync pin is forwarded to the timing logic after resynchronisation. In derived mode the block watches the pin for an edge of the selected polarity. The pin may then carry any periodic signal, such as a sensor shift clock. For each such edge the block emits a sync pulse one master clock wide, delayed by a programmable 0 to 7 master clocks.

A sample strobe follows every sync pulse. It marks the master clock edge at which downstream logic takes its sample: the first rising edge after the sync pulse has returned low. Edges that arrive while earlier pulses are still waiting out their delay are all kept, so every qualifying edge yields exactly one pulse. The configuration inputs (`derive_en`, `rise_sel`, `delay_sel`) are expected to stay static while pulses are pending.

Top module: `pixsync_gen`

## Requirements
- R1: With `derive_en` = 0, `sync_pulse` equals `sync_pin` delayed by exactly two master clocks (two synchroniser flops), whatever the values of `rise_sel` and `delay_sel`.
- R2: With `derive_en` = 1 and `rise_sel` = 1, each 0-to-1 transition of `sync_pin` produces one pulse and a 1-to-0 transition produces none.
- R3: With `derive_en` = 1 and `rise_sel` = 0, each 1-to-0 transition of `sync_pin` produces one pulse and a 0-to-1 transition produces none.
- R4: In derived mode, call the first rising clock edge that samples the new pin level edge 1. The pulse is then high in the cycle that starts at edge 3+D, where D is the unsigned value of `delay_sel` (0 to 7).
- R5: In derived mode every pulse on `sync_pulse` is high for exactly one master clock cycle.
- R6: A second qualifying pin edge that arrives while an earlier pulse is still delayed produces its own pulse, with its own R4 timing. No pulse is lost or merged.
- R7: `sample_stb` is high for exactly one clock cycle, namely the cycle that starts at the rising edge where `sync_pulse` goes from 1 to 0. It stays low otherwise.
- R8: While `rst_n` is low at a clock edge, both outputs go low and every pending delayed pulse is discarded, so no pulse appears after reset is released for an edge seen before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_pin | input | 1 | External sync or periodic sensor clock, asynchronous |
| derive_en | input | 1 | 1 = derive pulses from pin edges, 0 = pass pin through |
| rise_sel | input | 1 | Edge polarity in derived mode: 1 = rising, 0 = falling |
| delay_sel | input | 3 | Extra delay in master clocks (0 to 7) in derived mode |
| sync_pulse | output | 1 | Internal sync pulse |
| sample_stb | output | 1 | One-cycle strobe on the first clock after the pulse ends |

## Verification
A corrupted synchroniser or edge register shows up at the ports as a pulse for the wrong polarity, or as no pulse at all. It also shows as a pulse one clock early or late, and this is visible within three clocks of the pin change for a zero delay. A broken delay stage or tap select moves or removes the pulse within 3+D clocks. A stage that fails to clear on reset produces a stray pulse within eight clocks of reset release. Overlapping edges at the longest delay show whether the delay line drops or merges pulses. The strobe is checked at the exact cycle after each pulse.

// File: rtl/pixsync_pkg.sv
// Package: shared types and defaults for the pixel sync pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pixsync_pkg;
    // Number of flops in the pin synchroniser.
    localparam int SYNC_STAGES_DEF = 2;
    // Width of the delay select field.
    localparam int DLY_W_DEF = 3;

    // Polarity selection for the edge detector.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/pixsync_sync.sv
// Module: pixsync_sync
// Resynchronises an asynchronous level into the clk domain through a chain
// of STAGES flops. Assumes STAGES >= 1; the output lags the input by STAGES clocks.
module pixsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 1) begin : g_single
            logic ff;
            // Purpose: single-flop capture of the input level.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= 1'b0;
                else        ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            // Purpose: shift the input level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pixsync_edge.sv
// Module: pixsync_edge
// Detects one transition of the selected polarity on a synchronised level.
// Assumes lvl is already in the clk domain. hit is high for one cycle per
// qualifying transition and is forced low while enable is low.
module pixsync_edge
    import pixsync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  logic      enable,
    input  edge_sel_e sel,
    output logic      hit
);
    logic lvl_q;

    // Purpose: remember the previous level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Purpose: flag a transition of the requested polarity.
    always_comb begin
        if (sel == EDGE_RISE) hit = enable & lvl & ~lvl_q;
        else                  hit = enable & ~lvl & lvl_q;
    end
endmodule

// File: rtl/pixsync_dline.sv
// Module: pixsync_dline
// Delay line of DEPTH single-bit stages with a selectable output tap.
// Every stage is kept, so several pending pulses travel independently.
// Assumes DEPTH == 2**SEL_W; tap 0 is the input delayed by one clock.
module pixsync_dline #(
    parameter int SEL_W = 3,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    logic [DEPTH-1:0] stage;

    // Purpose: first stage captures the incoming event.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= din;
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            // Purpose: advance pending events by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 1'b0;
                else        stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign tap = stage[sel];
endmodule

// File: rtl/pixsync_strobe.sv
// Module: pixsync_strobe
// Raises stb for the one cycle that follows the falling edge of pulse.
// Assumes pulse is driven from clk-domain flops.
module pixsync_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic stb
);
    logic pulse_q;

    // Purpose: hold the previous pulse level.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse;
    end

    // Purpose: strobe while the pulse has just ended.
    assign stb = pulse_q & ~pulse;
endmodule

// File: rtl/pixsync_gen.sv
// Module: pixsync_gen (top)
// Pixel sync pulse generator. The pin is synchronised (SYNC_STAGES flops). In
// pass-through mode the synchronised level is the sync pulse. In derived mode
// a selected edge enters a delay line and the tap picked by delay_sel is the
// pulse. A strobe follows each pulse. Assumes the configuration is static
// while pulses are pending and that rst_n is synchronous to clk.
module pixsync_gen
    import pixsync_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int DLY_W       = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pin,
    input  logic             derive_en,
    input  logic             rise_sel,
    input  logic [DLY_W-1:0] delay_sel,
    output logic             sync_pulse,
    output logic             sample_stb
);
    localparam int TAPS = 1 << DLY_W;

    logic pin_s;
    logic edge_hit;
    logic dly_tap;

    pixsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_pin),
        .q     (pin_s)
    );

    pixsync_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (pin_s),
        .enable (derive_en),
        .sel    (edge_sel_e'(rise_sel)),
        .hit    (edge_hit)
    );

    pixsync_dline #(.SEL_W(DLY_W), .DEPTH(TAPS)) u_dline (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (edge_hit),
        .sel   (delay_sel),
        .tap   (dly_tap)
    );

    // Purpose: choose derived pulse or pass-through level.
    assign sync_pulse = derive_en ? dly_tap : pin_s;

    pixsync_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (sync_pulse),
        .stb   (sample_stb)
    );
endmodule

// File: rtl/pixsync_gen_chk.sv
// Module: pixsync_gen_chk
// Port-level checker for pixsync_gen, bound to every instance below.
// The timing properties are written for the default two-flop synchroniser.
module pixsync_gen_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_pin,
    input logic             derive_en,
    input logic             rise_sel,
    input logic [DLY_W-1:0] delay_sel,
    input logic             sync_pulse,
    input logic             sample_stb
);
    generate
        if (SYNC_STAGES == 2) begin : g_two
            AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                (!derive_en && $past(rst_n) && $past(rst_n, 2))
                |-> (sync_pulse == $past(sync_pin, 2))) else $error("bypass"); // R1

            AST_RISE_DLY0: assert property (@(posedge clk) disable iff (!rst_n)
                (derive_en && $past(derive_en) && rise_sel && $past(rise_sel)
                 && delay_sel == '0 && $past(delay_sel) == '0
                 && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4))
                |-> (sync_pulse == ($past(sync_pin, 3) && !$past(sync_pin, 4)))) else $error("dly0"); // R4
        end
    endgenerate

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (derive_en && sync_pulse)
        |=> (!sync_pulse || !derive_en || !$stable(delay_sel))) else $error("width"); // R5

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb) else $error("strobe"); // R7
endmodule

bind pixsync_gen pixsync_gen_chk #(.SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pin   (sync_pin),
    .derive_en  (derive_en),
    .rise_sel   (rise_sel),
    .delay_sel  (delay_sel),
    .sync_pulse (sync_pulse),
    .sample_stb (sample_stb)
);

// File: tb/pixsync_gen_test.sv
// Directed bench for pixsync_gen. Inputs are driven on falling clock edges
// and outputs are sampled on falling edges. Index j of an observation is the
// j-th falling edge after the drive.
module pixsync_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pin = 1'b0;
    logic       derive_en = 1'b0;
    logic       rise_sel = 1'b1;
    logic [2:0] delay_sel = 3'd0;
    logic       sync_pulse;
    logic       sample_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pixsync_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pin   (sync_pin),
        .derive_en  (derive_en),
        .rise_sel   (rise_sel),
        .delay_sel  (delay_sel),
        .sync_pulse (sync_pulse),
        .sample_stb (sample_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watch n falling edges; report rising-pulse positions, high count, strobe data.
    task automatic observe(input int n, output int p1, output int p2, output int pcnt,
                           output int s1, output int scnt);
        bit last = 1'b0;
        p1 = -1; p2 = -1; pcnt = 0; s1 = -1; scnt = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (sync_pulse) begin
                pcnt++;
                if (!last) begin
                    if (p1 < 0) p1 = j;
                    else if (p2 < 0) p2 = j;
                end
            end
            if (sample_stb) begin
                scnt++;
                if (s1 < 0) s1 = j;
            end
            last = sync_pulse;
        end
    endtask

    task automatic settle(input bit en, input bit pol, input int d, input bit lvl);
        @(negedge clk);
        derive_en = en; rise_sel = pol; delay_sel = 3'(d);
        @(negedge clk);
        sync_pin = lvl;
        repeat (14) @(negedge clk);
    endtask

    // R8: outputs low right after reset.
    task automatic t_reset_state();
        @(negedge clk);
        check(sync_pulse == 1'b0, "R8 pulse after reset", sync_pulse, 0);
        check(sample_stb == 1'b0, "R8 strobe after reset", sample_stb, 0);
    endtask

    // R1/R7: pass-through follows pin by two clocks regardless of pol/delay.
    task automatic t_bypass(input bit pol, input int d);
        int p1, p2, pc, s1, sc, q1, q2, qc, t1, tc;
        settle(1'b0, pol, d, 1'b0);
        sync_pin = 1'b1;
        observe(4, p1, p2, pc, s1, sc);
        sync_pin = 1'b0;
        observe(6, q1, q2, qc, t1, tc);
        check(p1 == 2, "R1 bypass rise lag", p1, 2);
        check(pc + qc == 4, "R1 bypass width", pc + qc, 4);
        check(t1 == 2 && tc == 1 && sc == 0, "R7 bypass strobe index", t1, 2);
    endtask

    // R2/R3/R4/R5/R7: single qualifying edge with delay d.
    task automatic t_edge(input bit pol, input int d);
        int p1, p2, pc, s1, sc;
        settle(1'b1, pol, d, ~pol);
        sync_pin = pol;
        observe(14, p1, p2, pc, s1, sc);
        if (pol) check(pc == 1, "R2 rising edge pulse count", pc, 1);
        else     check(pc == 1, "R3 falling edge pulse count", pc, 1);
        check(p1 == 3 + d, "R4 pulse position", p1, 3 + d);
        check(pc == 1 && p2 < 0, "R5 pulse width", pc, 1);
        check(s1 == 4 + d && sc == 1, "R7 strobe position", s1, 4 + d);
    endtask

    // R2/R3: opposite transition yields no pulse.
    task automatic t_wrong_edge(input bit pol);
        int p1, p2, pc, s1, sc;
        settle(1'b1, pol, 2, pol);
        sync_pin = ~pol;
        observe(14, p1, p2, pc, s1, sc);
        if (pol) check(pc == 0, "R2 falling edge ignored", pc, 0);
        else     check(pc == 0, "R3 rising edge ignored", pc, 0);
        check(sc == 0, "R7 no strobe without pulse", sc, 0);
    endtask

    // R6: two rising edges inside the 7-clock delay window.
    task automatic t_overlap();
        int p1, p2, pc, s1, sc, a, b, c, e, f;
        settle(1'b1, 1'b1, 7, 1'b0);
        sync_pin = 1'b1; observe(2, a, b, c, e, f);
        sync_pin = 1'b0; observe(2, a, b, c, e, f);
        sync_pin = 1'b1; observe(2, a, b, c, e, f);
        sync_pin = 1'b0; observe(14, p1, p2, pc, s1, sc);
        check(p1 == 4, "R6 first pulse position", p1, 4);
        check(p2 == 8, "R6 second pulse position", p2, 8);
        check(pc == 2, "R6 pulse count", pc, 2);
        check(sc == 2, "R7 strobe per pulse", sc, 2);
    endtask

    // R8: reset discards a pending delayed pulse.
    task automatic t_reset_flush();
        int p1, p2, pc, s1, sc;
        settle(1'b1, 1'b1, 7, 1'b0);
        sync_pin = 1'b1;
        observe(3, p1, p2, pc, s1, sc);
        rst_n = 1'b0; sync_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sync_pulse == 1'b0 && sample_stb == 1'b0, "R8 outputs in reset", sync_pulse, 0);
        rst_n = 1'b1;
        observe(14, p1, p2, pc, s1, sc);
        check(pc == 0, "R8 pending pulse discarded", pc, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_bypass(1'b1, 5);
        t_bypass(1'b0, 0);
        t_edge(1'b1, 0);
        t_edge(1'b1, 3);
        t_edge(1'b1, 7);
        t_edge(1'b0, 0);
        t_edge(1'b0, 5);
        t_wrong_edge(1'b1);
        t_wrong_edge(1'b0);
        t_overlap();
        t_reset_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule